// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous EDO DRAM with 1024 rows alive. After reset it holds the memory untouched for a programmable start-up delay. It then runs a fixed burst of warm-up refresh cycles and only after that raises a ready flag. From then on it paces refresh requests so that every row is refreshed inside the retention window.

Each refresh is a CAS-before-RAS cycle. The block asks for the memory bus with a request line and holds the request until an arbiter grants it. While it owns the bus it drives the row strobe and both column strobes itself. Address, write enable and output enable are don't-care during such a cycle and the data pins stay released, so none of them appear here.

All timings are given in nanoseconds and converted to clock cycles through a clock-period parameter. Minimum timings round up to the next whole cycle. The refresh interval rounds down. If grants stay away, missed intervals pile up in a bounded backlog. A sticky error flag rises when the backlog would exceed its limit.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, `ras_n`, `lcas_n` and `ucas_n` are 1 and `ref_req`, `strobe_own`, `mem_ready` and `backlog_ovf` are 0.
- R2: Before the start-up delay has run out (its length in cycles is ceil(STARTUP_NS*1000/CLK_PS)), no request is raised and all strobes stay high.
- R3: After the start-up delay, exactly WARMUP_CYCLES refresh cycles complete before `mem_ready` rises. `mem_ready` then stays high until reset.
- R4: A refresh starts with `lcas_n` and `ucas_n` falling in the same cycle. `ras_n` falls exactly ceil(T_CSR_NS*1000/CLK_PS) cycles later, while both column strobes are still low.
- R5: Both column strobes stay low for exactly ceil(T_CHR_NS*1000/CLK_PS) cycles after `ras_n` falls, then rise together while `ras_n` is still low.
- R6: `ras_n` stays low for exactly ceil(T_RAS_NS*1000/CLK_PS) cycles. After it rises, the bus is held for a precharge of max(ceil(T_RP_NS), ceil(T_RC_NS) minus the low time) cycles before `strobe_own` drops.
- R7: Once ready, one refresh is owed every floor(RETENTION_NS*1000/(ROWS*CLK_PS)) cycles. With prompt grants, `ref_req` rises at exactly that spacing.
- R8: `ref_req` stays high until a cycle in which `ref_gnt` is also high. A grant while `ref_req` is low starts nothing.
- R9: Owed refreshes are counted up to BACKLOG_MAX. An interval that falls due with the backlog already full sets `backlog_ovf`, which stays set until reset.
- R10: Strobes go low only while `strobe_own` is high. Whenever `strobe_own` is low, all three strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Bus grant from the arbiter; a refresh starts when it meets `ref_req` |
| ref_req | output | 1 | Refresh bus request |
| strobe_own | output | 1 | High while the block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| mem_ready | output | 1 | Start-up delay and warm-up burst complete |
| backlog_ovf | output | 1 | Sticky refresh backlog overflow |

## Verification
The bench keeps the 250 MHz period but shrinks the start-up delay to 400 ns (100 cycles). It also shrinks the retention window to 409.6 µs over 1024 rows, which gives a 100-cycle refresh interval. Warm-up, dozens of paced refreshes and a full backlog overflow therefore all fit in a few thousand cycles. The strobe minimums keep their device values and become 2, 3, 15 and 11 cycles. Grants arrive at random, including while no request is pending. For ten intervals they are withheld entirely, which drives the backlog through its limit.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CAS_LEAD,
        SEQ_RAS_ACT,
        SEQ_PRECHG
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    // Minimum timing: round up to whole cycles.
    function automatic int unsigned cyc_ceil(longint unsigned ns, longint unsigned clk_ps);
        return int'((ns * 1000 + clk_ps - 1) / clk_ps);
    endfunction

    // Maximum spacing: round down to whole cycles.
    function automatic int unsigned cyc_floor(longint unsigned ns, longint unsigned div_ps);
        return int'((ns * 1000) / div_ps);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_startup_timer.sv
module drs_startup_timer #(
    parameter int unsigned STARTUP_C = 100
) (
    input  logic clk,
    input  logic rst,
    output logic start_done
);
    localparam int unsigned SW = $clog2(STARTUP_C + 1);
    localparam logic [SW-1:0] LAST = SW'(STARTUP_C - 1);

    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            start_done <= 1'b0;
        end else if (!start_done) begin
            if (cnt == LAST) start_done <= 1'b1;
            else             cnt        <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drs_refresh_pacer.sv
module drs_refresh_pacer #(
    parameter int unsigned INT_C       = 100,
    parameter int unsigned WARMUP      = 8,
    parameter int unsigned BACKLOG_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_done,
    input  logic cyc_done,
    output logic pending,
    output logic mem_ready,
    output logic backlog_ovf
);
    localparam int unsigned WW = $clog2(WARMUP + 1);
    localparam int unsigned BW = $clog2(BACKLOG_MAX + 1);
    localparam int unsigned IW = (INT_C > 1) ? $clog2(INT_C) : 1;
    localparam logic [IW-1:0] IV_LAST = IW'(INT_C - 1);
    localparam logic [BW-1:0] BL_FULL = BW'(BACKLOG_MAX);

    logic [WW-1:0] warm_left;
    logic [BW-1:0] backlog;
    logic [IW-1:0] iv_cnt;
    logic          tick;

    assign mem_ready = start_done && (warm_left == '0);
    assign tick      = mem_ready && (iv_cnt == IV_LAST);
    assign pending   = start_done && ((warm_left != '0) || (backlog != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_cnt <= '0;
        end else if (mem_ready) begin
            iv_cnt <= tick ? '0 : iv_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_left   <= WW'(WARMUP);
            backlog     <= '0;
            backlog_ovf <= 1'b0;
        end else if (cyc_done && (warm_left != '0)) begin
            warm_left <= warm_left - 1'b1;
        end else if (tick && !cyc_done) begin
            if (backlog == BL_FULL) backlog_ovf <= 1'b1;
            else                    backlog     <= backlog + 1'b1;
        end else if (cyc_done && !tick && (backlog != '0)) begin
            backlog <= backlog - 1'b1;
        end
    end

    // Ready and overflow are one-way until reset.
    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        mem_ready |=> mem_ready);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        backlog_ovf |=> backlog_ovf);
    p_backlog_bound_r9: assert property (@(posedge clk) disable iff (rst)
        backlog <= BL_FULL);
endmodule

// File: rtl/drs_cbr_seq.sv
module drs_cbr_seq
    import drs_pkg::*;
#(
    parameter int unsigned CSR_C = 2,
    parameter int unsigned CHR_C = 3,
    parameter int unsigned RAS_C = 15,
    parameter int unsigned PRE_C = 11
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output strobe_t strobe,
    output logic    busy,
    output logic    cyc_done
);
    localparam int unsigned CMAX = max_u(max_u(CSR_C, RAS_C), PRE_C);
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] CSR_LAST = CW'(CSR_C - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(RAS_C - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_C - 1);
    localparam logic [CW-1:0] CHR_LIM  = CW'(CHR_C);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    cnt <= '0;
                    if (start) state <= SEQ_CAS_LEAD;
                end
                SEQ_CAS_LEAD: begin
                    if (cnt == CSR_LAST) begin
                        state <= SEQ_RAS_ACT;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                SEQ_RAS_ACT: begin
                    if (cnt == RAS_LAST) begin
                        state <= SEQ_PRECHG;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                SEQ_PRECHG: begin
                    if (cnt == PRE_LAST) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe.ras_n = (state != SEQ_RAS_ACT);
        strobe.cas_n = !((state == SEQ_CAS_LEAD) ||
                         ((state == SEQ_RAS_ACT) && (cnt < CHR_LIM)));
        busy         = (state != SEQ_IDLE);
        cyc_done     = (state == SEQ_PRECHG) && (cnt == PRE_LAST);
    end

    // Column strobes release only while the row strobe is still active.
    p_cas_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe.cas_n) |-> !strobe.ras_n);
    // A new cycle cannot begin while one is running.
    p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !cyc_done) |=> busy);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import drs_pkg::*;
#(
    parameter longint unsigned CLK_PS        = 4000,
    parameter longint unsigned STARTUP_NS    = 200_000_000,
    parameter int unsigned     WARMUP_CYCLES = 8,
    parameter int unsigned     ROWS          = 1024,
    parameter longint unsigned RETENTION_NS  = 16_000_000,
    parameter longint unsigned T_CSR_NS      = 5,
    parameter longint unsigned T_CHR_NS      = 10,
    parameter longint unsigned T_RAS_NS      = 60,
    parameter longint unsigned T_RP_NS       = 40,
    parameter longint unsigned T_RC_NS       = 104,
    parameter int unsigned     BACKLOG_MAX   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic strobe_own,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic mem_ready,
    output logic backlog_ovf
);
    localparam int unsigned STARTUP_C = cyc_ceil(STARTUP_NS, CLK_PS);
    localparam int unsigned CSR_C     = cyc_ceil(T_CSR_NS, CLK_PS);
    localparam int unsigned CHR_C     = cyc_ceil(T_CHR_NS, CLK_PS);
    localparam int unsigned RAS_C     = cyc_ceil(T_RAS_NS, CLK_PS);
    localparam int unsigned RP_C      = cyc_ceil(T_RP_NS, CLK_PS);
    localparam int unsigned RC_C      = cyc_ceil(T_RC_NS, CLK_PS);
    localparam int unsigned PRE_C     = max_u(RP_C, (RC_C > RAS_C) ? RC_C - RAS_C : 0);
    localparam int unsigned INT_C     = cyc_floor(RETENTION_NS, longint'(ROWS) * CLK_PS);

    logic    start_done;
    logic    pending;
    logic    cyc_done;
    logic    busy;
    logic    start;
    strobe_t strobe;

    drs_startup_timer #(.STARTUP_C(STARTUP_C)) u_startup (
        .clk        (clk),
        .rst        (rst),
        .start_done (start_done)
    );

    drs_refresh_pacer #(
        .INT_C       (INT_C),
        .WARMUP      (WARMUP_CYCLES),
        .BACKLOG_MAX (BACKLOG_MAX)
    ) u_pacer (
        .clk         (clk),
        .rst         (rst),
        .start_done  (start_done),
        .cyc_done    (cyc_done),
        .pending     (pending),
        .mem_ready   (mem_ready),
        .backlog_ovf (backlog_ovf)
    );

    drs_cbr_seq #(
        .CSR_C (CSR_C),
        .CHR_C (CHR_C),
        .RAS_C (RAS_C),
        .PRE_C (PRE_C)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .strobe   (strobe),
        .busy     (busy),
        .cyc_done (cyc_done)
    );

    assign ref_req    = pending && !busy;
    assign start      = ref_req && ref_gnt;
    assign strobe_own = busy;
    assign ras_n      = strobe.ras_n;
    assign lcas_n     = strobe.cas_n;
    assign ucas_n     = strobe.cas_n;

    // Row strobe falls only after both column strobes were already low.
    p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!lcas_n && !ucas_n && $past(!lcas_n) && $past(!ucas_n)));
    // A request is held until granted.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_gnt) |=> ref_req);
    // Memory untouched during the start-up wait.
    p_quiet_startup_r2: assert property (@(posedge clk) disable iff (rst)
        !start_done |-> (ras_n && lcas_n && ucas_n && !ref_req));
    // Strobes stay inactive when the bus is not owned.
    p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
        !strobe_own |-> (ras_n && lcas_n && ucas_n));
endmodule

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
    localparam longint CLK_PS  = 4000;
    localparam longint SU_NS   = 400;
    localparam int     WARM    = 8;
    localparam int     ROWSN   = 1024;
    localparam longint RET_NS  = 409_600;
    localparam int     BLMAX   = 8;

    // Expected cycle counts, worked out from the requirement formulas.
    localparam int E_SU  = 100;
    localparam int E_CSR = 2;
    localparam int E_CHR = 3;
    localparam int E_RAS = 15;
    localparam int E_PRE = 11;   // max(10, 26-15)
    localparam int E_INT = 100;
    localparam int E_TOT = E_CSR + E_RAS + E_PRE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, strobe_own, ras_n, lcas_n, ucas_n, mem_ready, backlog_ovf;

    int errors = 0;
    int checks = 0;
    bit gnt_en = 1'b0;
    int phase = 0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .CLK_PS(CLK_PS), .STARTUP_NS(SU_NS), .WARMUP_CYCLES(WARM), .ROWS(ROWSN),
        .RETENTION_NS(RET_NS), .T_CSR_NS(5), .T_CHR_NS(10), .T_RAS_NS(60),
        .T_RP_NS(40), .T_RC_NS(104), .BACKLOG_MAX(BLMAX)
    ) u0 (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .strobe_own(strobe_own), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .mem_ready(mem_ready), .backlog_ovf(backlog_ovf)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_t;        // cycles since reset release
    bit  m_su;
    int  m_warm;
    int  m_owed;
    bit  m_ovf;
    int  m_iv;
    int  m_pos;      // position inside a refresh, -1 when idle

    function automatic bit m_ready();   return m_su && (m_warm == 0); endfunction
    function automatic bit m_req();     return m_su && (m_warm > 0 || m_owed > 0) && (m_pos < 0); endfunction
    function automatic bit m_cas_low(); return (m_pos >= 0) && (m_pos < E_CSR + E_CHR); endfunction
    function automatic bit m_ras_low(); return (m_pos >= E_CSR) && (m_pos < E_CSR + E_RAS); endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_t = 0; m_su = 0; m_warm = WARM; m_owed = 0; m_ovf = 0; m_iv = 0; m_pos = -1;
        end else begin
            bit fin, due, go;
            fin = (m_pos == E_TOT - 1);
            due = m_ready() && (m_iv == E_INT - 1);
            go  = m_req() && ref_gnt;
            if (m_ready()) m_iv = due ? 0 : m_iv + 1;
            if (fin && m_warm > 0) m_warm--;
            else if (due && !fin) begin
                if (m_owed == BLMAX) m_ovf = 1; else m_owed++;
            end else if (fin && !due && m_owed > 0) m_owed--;
            if (go) m_pos = 0;
            else if (m_pos >= 0) m_pos = fin ? -1 : m_pos + 1;
            m_t++;
            if (!m_su && m_t >= E_SU) m_su = 1;
        end
    end

    // ---------------- per-cycle comparison and edge monitors ----------------
    int  t = 0;
    bit  p_ras = 1, p_lcas = 1, p_ucas = 1, p_own = 0, p_ready = 0, p_req = 0;
    int  t_casf, t_rasf, t_rasr;
    int  warm_seen = 0;
    bit  first_seen = 0;
    int  rise_n = 0, rise_first = 0, rise_last = 0;

    always @(negedge clk) begin
        if (!rst) begin
            t++;
            check(ras_n == !m_ras_low(), "R10 ras_n model", ras_n, !m_ras_low());
            check(lcas_n == !m_cas_low() && ucas_n == !m_cas_low(), "R10 cas model", lcas_n, !m_cas_low());
            check(strobe_own == (m_pos >= 0), "R6 strobe_own model", strobe_own, m_pos >= 0);
            check(ref_req == m_req(), "R8 ref_req model", ref_req, m_req());
            check(mem_ready == m_ready(), "R3 mem_ready model", mem_ready, m_ready());
            check(backlog_ovf == m_ovf, "R9 backlog_ovf model", backlog_ovf, m_ovf);
            if (!strobe_own)
                check(ras_n && lcas_n && ucas_n, "R10 strobes high when not owned", {ras_n, lcas_n, ucas_n}, 3'b111);

            if (p_lcas && !lcas_n) begin
                t_casf = t;
                check(!ucas_n && p_ucas, "R4 both column strobes fall together", ucas_n, 0);
                if (!first_seen) begin
                    first_seen = 1;
                    check(t >= E_SU + 1, "R2 first strobe after start-up delay", t, E_SU + 1);
                end
            end
            if (p_ras && !ras_n) begin
                t_rasf = t;
                check(t - t_casf == E_CSR, "R4 cas-to-ras lead", t - t_casf, E_CSR);
                if (!mem_ready) warm_seen++;
            end
            if (!p_lcas && lcas_n) begin
                check(t - t_rasf == E_CHR, "R5 cas hold after ras", t - t_rasf, E_CHR);
                check(ucas_n && !ras_n, "R5 strobes rise together under active ras", {ucas_n, ras_n}, 2'b10);
            end
            if (!p_ras && ras_n) begin
                t_rasr = t;
                check(t - t_rasf == E_RAS, "R6 ras low width", t - t_rasf, E_RAS);
            end
            if (p_own && !strobe_own)
                check(t - t_rasr == E_PRE, "R6 precharge hold", t - t_rasr, E_PRE);
            if (!p_ready && mem_ready)
                check(warm_seen == WARM, "R3 warm-up refresh count", warm_seen, WARM);
            if (phase == 1 && mem_ready && !p_req && ref_req) begin
                if (rise_n == 0) rise_first = t;
                rise_last = t;
                rise_n++;
            end
            p_ras = ras_n; p_lcas = lcas_n; p_ucas = ucas_n;
            p_own = strobe_own; p_ready = mem_ready; p_req = ref_req;
        end
    end

    // Random grants, also while nothing is requested (R8).
    initial begin
        forever begin
            @(negedge clk);
            ref_gnt = gnt_en && ($urandom_range(0, 2) == 0);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(ras_n && lcas_n && ucas_n, "R1 strobes high in reset", {ras_n, lcas_n, ucas_n}, 3'b111);
        check(!ref_req && !strobe_own, "R1 no request in reset", {ref_req, strobe_own}, 0);
        check(!mem_ready && !backlog_ovf, "R1 flags low in reset", {mem_ready, backlog_ovf}, 0);
        rst = 1'b0;
        gnt_en = 1'b1;
        while (!mem_ready) @(negedge clk);
        phase = 1;
        repeat (20 * E_INT) @(negedge clk);
        phase = 2;
        check(rise_n >= 10, "R7 enough paced requests", rise_n, 10);
        check(rise_last - rise_first == (rise_n - 1) * E_INT, "R7 average request period",
              rise_last - rise_first, (rise_n - 1) * E_INT);
        check(!backlog_ovf, "R9 no overflow with prompt grants", backlog_ovf, 0);
        gnt_en = 1'b0;
        repeat (10 * E_INT + 5) @(negedge clk);
        check(ref_req, "R8 request held without grant", ref_req, 1);
        check(backlog_ovf, "R9 overflow after withheld grants", backlog_ovf, 1);
        gnt_en = 1'b1;
        repeat (15 * E_INT) @(negedge clk);
        check(backlog_ovf, "R9 overflow flag sticky", backlog_ovf, 1);
        check(mem_ready, "R3 ready stays high", mem_ready, 1);
        finish_run();
    end
endmodule